// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Request/Clear Flow Control

This block is a full-duplex asynchronous serial link endpoint. A single clock-enable input, pulsing at sixteen times the bit rate, sets the line timing for both directions. On the send side a byte is handed over through a valid/ready handshake. The block shifts it out least significant bit first, with a low start bit, the configured number of data bits, an optional parity bit and a high stop bit. On the receive side the block watches the line for a falling edge. It confirms the start bit at mid-bit, samples every later bit at its centre and places the result in a one-byte holding register, together with flags for a bad stop bit and for a parity mismatch.

Both directions respect the partner's readiness. A frame starts only while the synchronised clear-to-send input is high. A frame that is already on the line always runs to its end. The request-to-send output stays high while the holding register is empty, and it drops as soon as a received byte waits to be taken. Word length (5 to 8 bits) and parity mode are run-time inputs and must be held steady while a frame is in flight.

Top module: `uart_modem_link`

## Requirements
- R1: After reset, and whenever no frame is being sent, `txd` is high; `tx_ready` is high only while the sender is idle and the synchronised `cts_in` is high.
- R2: An accepted byte starts a frame on the next clock: one low start bit, the data bits least significant first, the optional parity bit and one high stop bit, each bit lasting 16 `os_tick` pulses.
- R3: `cfg_len` selects the word length as 5 + `cfg_len` (0 gives 5 bits, 3 gives 8). Unused upper bits of `tx_data` are not sent, and the unused upper bits of `rx_data` read as 0.
- R4: `cfg_par` selects parity: 0 none, 1 odd (data ones plus parity bit give an odd count), 2 even, 3 space (always 0), 4 mark (always 1). Codes 5 to 7 act as none.
- R5: The receiver confirms a start bit on the 8th tick after the falling edge. A line that is high again at that point is treated as a glitch and delivers no byte.
- R6: Each received bit is sampled 16 ticks after the previous sample point. The byte appears on `rx_data` with `rx_valid` high and stays unchanged until a cycle with `rx_ready` high takes it.
- R7: A low level at the stop-bit sample point sets `rx_frm_err` alongside the delivered byte.
- R8: A received parity bit that differs from the one computed for the selected mode sets `rx_par_err` alongside the delivered byte.
- R9: While `cts_in` is low no new frame starts. A frame already on the line completes unchanged, and the next frame waits until `cts_in` rises.
- R10: `rts_out` is high exactly while the holding register is empty. A byte that completes while the register is full is dropped, and the held byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Clock enable at 16 times the bit rate |
| cfg_len | input | 2 | Word length code, length = 5 + code |
| cfg_par | input | 3 | Parity mode code |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` holds a byte to send |
| tx_ready | output | 1 | Sender accepts a byte this cycle |
| txd | output | 1 | Serial output line, idle high |
| cts_in | input | 1 | Partner is ready to receive (asynchronous) |
| rxd | input | 1 | Serial input line, idle high (asynchronous) |
| rx_data | output | 8 | Received byte, right-aligned |
| rx_valid | output | 1 | Holding register is full |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_frm_err | output | 1 | Held byte had a low stop bit |
| rx_par_err | output | 1 | Held byte had a parity mismatch |
| rts_out | output | 1 | Local side can accept a byte |

## Verification
A sender state or bit counter that slips shows within one frame, as a shifted data pattern, a wrong parity bit or a stop bit that is too short at the mid-bit samples of the independent line monitor. A receiver counter that is off by even a few ticks moves the sample points to the bit edges. The byte or the error flags then go wrong on the first frame that follows. Faults in flow control show at the port as a frame that starts while clear-to-send is low, or as a request-to-send level that disagrees with the byte still held. A held byte that is overwritten shows when the consumer finally takes it.

// File: rtl/uart_link_pkg.sv
package uart_link_pkg;

  typedef enum logic [2:0] {
    LS_IDLE  = 3'd0,
    LS_START = 3'd1,
    LS_DATA  = 3'd2,
    LS_PAR   = 3'd3,
    LS_STOP  = 3'd4
  } link_state_e;

  localparam logic [2:0] PM_NONE  = 3'd0;
  localparam logic [2:0] PM_ODD   = 3'd1;
  localparam logic [2:0] PM_EVEN  = 3'd2;
  localparam logic [2:0] PM_SPACE = 3'd3;
  localparam logic [2:0] PM_MARK  = 3'd4;

  // Mask of the data bits that belong to the word for a given length code.
  function automatic logic [7:0] len_mask(input logic [1:0] len_code);
    return 8'hFF >> (2'd3 - len_code);
  endfunction

  // Index of the last data bit for a given length code (4..7).
  function automatic logic [2:0] last_index(input logic [1:0] len_code);
    return 3'(len_code) + 3'd4;
  endfunction

  function automatic logic parity_used(input logic [2:0] mode);
    return (mode == PM_ODD) || (mode == PM_EVEN) ||
           (mode == PM_SPACE) || (mode == PM_MARK);
  endfunction

  // Parity bit for already-masked data.
  function automatic logic parity_value(input logic [7:0] data, input logic [2:0] mode);
    logic pv;
    case (mode)
      PM_ODD:   pv = ~(^data);
      PM_EVEN:  pv = ^data;
      PM_MARK:  pv = 1'b1;
      default:  pv = 1'b0;
    endcase
    return pv;
  endfunction

endpackage

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_link_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  input  logic       cts_ok,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd
);

  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);

  link_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       idx_q, idx_d;
  logic [7:0]       sh_q, sh_d;
  logic             par_q, par_d;
  logic             txd_q, txd_d;
  logic [7:0]       masked;

  assign masked   = tx_data & len_mask(cfg_len);
  assign tx_ready = (st_q == LS_IDLE) && cts_ok;
  assign txd      = txd_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    par_d = par_q;
    txd_d = txd_q;
    if (st_q == LS_IDLE) begin
      txd_d = 1'b1;
      if (tx_valid && tx_ready) begin
        st_d  = LS_START;
        cnt_d = '0;
        txd_d = 1'b0;
        sh_d  = masked;
        par_d = parity_value(masked, cfg_par);
      end
    end else if (os_tick) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        case (st_q)
          LS_START: begin
            st_d  = LS_DATA;
            idx_d = '0;
            txd_d = sh_q[0];
            sh_d  = {1'b0, sh_q[7:1]};
          end
          LS_DATA: begin
            if (idx_q == last_index(cfg_len)) begin
              if (parity_used(cfg_par)) begin
                st_d  = LS_PAR;
                txd_d = par_q;
              end else begin
                st_d  = LS_STOP;
                txd_d = 1'b1;
              end
            end else begin
              idx_d = idx_q + 3'd1;
              txd_d = sh_q[0];
              sh_d  = {1'b0, sh_q[7:1]};
            end
          end
          LS_PAR: begin
            st_d  = LS_STOP;
            txd_d = 1'b1;
          end
          default: begin
            st_d  = LS_IDLE;
            txd_d = 1'b1;
          end
        endcase
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LS_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
      txd_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      par_q <= par_d;
      txd_q <= txd_d;
    end
  end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_link_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  input  logic       rxd,
  output logic       rx_done,
  output logic [7:0] rx_byte,
  output logic       rx_ferr,
  output logic       rx_perr
);

  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OS_RATE / 2 - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxs;

  link_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       idx_q, idx_d;
  logic [7:0]       sh_q, sh_d;
  logic             pbit_q, pbit_d;
  logic             done_q, done_d;
  logic [7:0]       byte_q, byte_d;
  logic             ferr_q, ferr_d;
  logic             perr_q, perr_d;
  logic [7:0]       aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end
  assign rxs = sync_q[SYNC_STAGES-1];

  assign aligned = sh_q >> (2'd3 - cfg_len);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    pbit_d = pbit_q;
    done_d = 1'b0;
    byte_d = byte_q;
    ferr_d = ferr_q;
    perr_d = perr_q;
    case (st_q)
      LS_IDLE: begin
        if (!rxs) begin
          st_d  = LS_START;
          cnt_d = '0;
        end
      end
      LS_START: begin
        if (os_tick) begin
          if (cnt_q == CNT_MID) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = rxs ? LS_IDLE : LS_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      LS_DATA: begin
        if (os_tick) begin
          if (cnt_q == CNT_LAST) begin
            cnt_d = '0;
            sh_d  = {rxs, sh_q[7:1]};
            if (idx_q == last_index(cfg_len))
              st_d = parity_used(cfg_par) ? LS_PAR : LS_STOP;
            else
              idx_d = idx_q + 3'd1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      LS_PAR: begin
        if (os_tick) begin
          if (cnt_q == CNT_LAST) begin
            cnt_d  = '0;
            pbit_d = rxs;
            st_d   = LS_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        if (os_tick) begin
          if (cnt_q == CNT_LAST) begin
            cnt_d  = '0;
            st_d   = LS_IDLE;
            done_d = 1'b1;
            byte_d = aligned;
            ferr_d = !rxs;
            perr_d = parity_used(cfg_par) &&
                     (pbit_q != parity_value(aligned, cfg_par));
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LS_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      done_q <= 1'b0;
      byte_q <= '0;
      ferr_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      pbit_q <= pbit_d;
      done_q <= done_d;
      byte_q <= byte_d;
      ferr_q <= ferr_d;
      perr_q <= perr_d;
    end
  end

  assign rx_done = done_q;
  assign rx_byte = byte_q;
  assign rx_ferr = ferr_q;
  assign rx_perr = perr_q;

endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_in,
  output logic       cts_ok,
  input  logic       rx_done,
  input  logic [7:0] rx_byte,
  input  logic       rx_ferr,
  input  logic       rx_perr,
  input  logic       rx_ready,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_frm_err,
  output logic       rx_par_err,
  output logic       rts_out
);

  logic [SYNC_STAGES-1:0] cts_q;

  logic       full_q, full_d;
  logic [7:0] data_q, data_d;
  logic       ferr_q, ferr_d;
  logic       perr_q, perr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_q <= '0;
    else        cts_q <= {cts_q[SYNC_STAGES-2:0], cts_in};
  end
  assign cts_ok = cts_q[SYNC_STAGES-1];

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    ferr_d = ferr_q;
    perr_d = perr_q;
    if (full_q && rx_ready) begin
      full_d = 1'b0;
      ferr_d = 1'b0;
      perr_d = 1'b0;
    end else if (rx_done && !full_q) begin
      full_d = 1'b1;
      data_d = rx_byte;
      ferr_d = rx_ferr;
      perr_d = rx_perr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      ferr_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
      ferr_q <= ferr_d;
      perr_q <= perr_d;
    end
  end

  assign rx_valid   = full_q;
  assign rx_data    = data_q;
  assign rx_frm_err = ferr_q;
  assign rx_par_err = perr_q;
  assign rts_out    = !full_q;

endmodule

// File: rtl/uart_modem_link.sv
module uart_modem_link #(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd,
  input  logic       cts_in,
  input  logic       rxd,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       rx_frm_err,
  output logic       rx_par_err,
  output logic       rts_out
);

  logic       cts_ok;
  logic       done;
  logic [7:0] got_byte;
  logic       got_ferr;
  logic       got_perr;

  uart_flow_ctl #(.SYNC_STAGES(SYNC_STAGES)) flow_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cts_in     (cts_in),
    .cts_ok     (cts_ok),
    .rx_done    (done),
    .rx_byte    (got_byte),
    .rx_ferr    (got_ferr),
    .rx_perr    (got_perr),
    .rx_ready   (rx_ready),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_frm_err (rx_frm_err),
    .rx_par_err (rx_par_err),
    .rts_out    (rts_out)
  );

  uart_tx_core #(.OS_RATE(OS_RATE)) tx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_tick  (os_tick),
    .cfg_len  (cfg_len),
    .cfg_par  (cfg_par),
    .cts_ok   (cts_ok),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd)
  );

  uart_rx_core #(.OS_RATE(OS_RATE), .SYNC_STAGES(SYNC_STAGES)) rx_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .os_tick (os_tick),
    .cfg_len (cfg_len),
    .cfg_par (cfg_par),
    .rxd     (rxd),
    .rx_done (done),
    .rx_byte (got_byte),
    .rx_ferr (got_ferr),
    .rx_perr (got_perr)
  );

endmodule

// File: rtl/uart_modem_link_chk.sv
module uart_modem_link_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       cts_in,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       rx_frm_err,
  input logic       rx_par_err
);

  logic [3:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (cts_in)         low_run <= '0;
    else if (low_run != 4'hF) low_run <= low_run + 4'd1;
  end

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  // R2
  start_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !txd);

  // R9
  cts_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_in && (low_run >= 4'(SYNC_STAGES))) |-> !tx_ready);

  // R6
  held_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R7
  flags_need_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frm_err || rx_par_err) |-> rx_valid);

endmodule

bind uart_modem_link uart_modem_link_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .txd        (txd),
  .cts_in     (cts_in),
  .rx_data    (rx_data),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_frm_err (rx_frm_err),
  .rx_par_err (rx_par_err)
);

// File: tb/uart_modem_link_tb_top.sv
module uart_modem_link_tb_top;

  localparam int BITCLK = 64;

  logic       clk;
  logic       rst_n;
  logic       os_tick;
  logic [1:0] cfg_len;
  logic [2:0] cfg_par;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic       txd;
  logic       cts_in;
  logic       rxd;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready;
  logic       rx_frm_err;
  logic       rx_par_err;
  logic       rts_out;

  int  n_tests;
  int  n_fail;
  int  frames_seen;
  bit  rx_take;
  bit  finished;
  int  tick_div;
  int  txq[$];
  int  rxq[$];

  uart_modem_link dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .cts_in(cts_in), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_frm_err(rx_frm_err), .rx_par_err(rx_par_err),
    .rts_out(rts_out)
  );

  assign rx_ready = rx_take;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    tick_div = 0;
    os_tick  = 1'b0;
  end
  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 4;
    os_tick  = (tick_div == 0);
  end

  function automatic int nbits();
    return 5 + int'(cfg_len);
  endfunction

  function automatic logic [7:0] wmask();
    return 8'((1 << nbits()) - 1);
  endfunction

  function automatic bit has_par();
    return (cfg_par >= 3'd1) && (cfg_par <= 3'd4);
  endfunction

  function automatic bit exp_par(input logic [7:0] d);
    int ones = $countones(d);
    case (cfg_par)
      3'd1: return (ones % 2) == 0;
      3'd2: return (ones % 2) == 1;
      3'd4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Line monitor for txd: samples each bit in its middle.
  initial begin
    frames_seen = 0;
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        logic [7:0] d;
        logic p, s;
        int exp_d;
        frames_seen++;
        d = '0;
        p = 1'b0;
        repeat (BITCLK / 2) @(negedge clk);
        check(txd === 1'b0, "R2 start bit", int'(txd), 0);
        for (int i = 0; i < nbits(); i++) begin
          repeat (BITCLK) @(negedge clk);
          d[i] = txd;
        end
        if (has_par()) begin
          repeat (BITCLK) @(negedge clk);
          p = txd;
        end
        repeat (BITCLK) @(negedge clk);
        s = txd;
        if (txq.size() == 0) begin
          check(1'b0, "R9 unexpected tx frame", int'(d), 0);
        end else begin
          exp_d = txq.pop_front();
          check(d == 8'(exp_d), "R2/R3 tx data", int'(d), exp_d);
          if (has_par())
            check(p == exp_par(8'(exp_d)), "R4 tx parity", int'(p), int'(exp_par(8'(exp_d))));
          check(s === 1'b1, "R2 tx stop bit", int'(s), 1);
        end
      end
    end
  end

  // Receive scoreboard: pops when the consumer takes a byte.
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_take) begin
      int act;
      int exp_v;
      act = {22'd0, rx_par_err, rx_frm_err, rx_data};
      if (rxq.size() == 0) begin
        check(1'b0, "R5/R10 unexpected rx byte", act, 0);
      end else begin
        exp_v = rxq.pop_front();
        check(act == exp_v, "R6/R7/R8 rx byte+flags", act, exp_v);
      end
    end
  end

  task automatic send_tx(input logic [7:0] d);
    txq.push_back(int'(d & wmask()));
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_tx_done();
    while (txq.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b, input int n);
    rxd = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit keep);
    logic [7:0] m;
    logic pb;
    m  = d & wmask();
    pb = exp_par(m) ^ bad_par;
    if (keep)
      rxq.push_back({22'd0, bad_par & has_par(), bad_stop, m});
    drive_bit(1'b0, BITCLK);
    for (int i = 0; i < nbits(); i++) drive_bit(m[i], BITCLK);
    if (has_par()) drive_bit(pb, BITCLK);
    if (bad_stop) begin
      drive_bit(1'b0, 48);
      drive_bit(1'b1, BITCLK);
    end else begin
      drive_bit(1'b1, BITCLK);
    end
    drive_bit(1'b1, 16);
  endtask

  task automatic wait_rx_done();
    while (rxq.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic [2:0] p);
    cfg_len = l;
    cfg_par = p;
    repeat (4) @(negedge clk);
  endtask

  task automatic loop_case(input logic [1:0] l, input logic [2:0] p, input logic [7:0] d);
    set_cfg(l, p);
    send_tx(d);
    wait_tx_done();
    send_rx(d, 1'b0, 1'b0, 1'b1);
    wait_rx_done();
  endtask

  initial begin
    finished = 1'b0;
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    n_tests  = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    cfg_len  = 2'd3;
    cfg_par  = 3'd0;
    tx_data  = '0;
    tx_valid = 1'b0;
    cts_in   = 1'b1;
    rxd      = 1'b1;
    rx_take  = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 / R10 reset state
    check(txd === 1'b1, "R1 idle txd", int'(txd), 1);
    check(tx_ready === 1'b1, "R1 ready when idle", int'(tx_ready), 1);
    check(rx_valid === 1'b0, "R6 no byte after reset", int'(rx_valid), 0);
    check(rts_out === 1'b1, "R10 rts after reset", int'(rts_out), 1);

    // R2 R3 R4 loopback-style patterns in both directions
    loop_case(2'd3, 3'd0, 8'hA5);
    loop_case(2'd2, 3'd2, 8'hDC);
    loop_case(2'd0, 3'd1, 8'hF3);
    loop_case(2'd1, 3'd4, 8'h2D);
    loop_case(2'd3, 3'd3, 8'hC6);
    loop_case(2'd3, 3'd1, 8'h00);
    loop_case(2'd0, 3'd6, 8'hFF);

    // R8 parity mismatch
    set_cfg(2'd3, 3'd2);
    send_rx(8'h81, 1'b1, 1'b0, 1'b1);
    wait_rx_done();
    // R7 low stop bit
    set_cfg(2'd3, 3'd0);
    send_rx(8'h3C, 1'b0, 1'b1, 1'b1);
    wait_rx_done();

    // R5 glitch shorter than half a bit
    drive_bit(1'b0, 12);
    drive_bit(1'b1, 300);
    check(rx_valid === 1'b0, "R5 glitch ignored", int'(rx_valid), 0);
    send_rx(8'h6E, 1'b0, 1'b0, 1'b1);
    wait_rx_done();

    // R9 CTS low blocks a new frame
    cts_in = 1'b0;
    repeat (5) @(negedge clk);
    base = frames_seen;
    fork send_tx(8'h77); join_none
    repeat (400) @(negedge clk);
    check(frames_seen == base, "R9 no start while cts low", frames_seen - base, 0);
    check(txd === 1'b1, "R9 line idle while cts low", int'(txd), 1);
    cts_in = 1'b1;
    wait_tx_done();
    check(frames_seen == base + 1, "R9 frame after cts rises", frames_seen - base, 1);

    // R9 CTS drop mid-frame: current frame completes, next one waits
    base = frames_seen;
    fork
      begin
        send_tx(8'h11);
        send_tx(8'h22);
      end
    join_none
    while (frames_seen == base) @(negedge clk);
    repeat (100) @(negedge clk);
    cts_in = 1'b0;
    while (txq.size() > 1) @(negedge clk);
    repeat (400) @(negedge clk);
    check(frames_seen == base + 1, "R9 second frame held", frames_seen - base, 1);
    cts_in = 1'b1;
    wait_tx_done();
    check(frames_seen == base + 2, "R9 second frame sent", frames_seen - base, 2);

    // R10 full buffer drops RTS and drops an extra byte
    rx_take = 1'b0;
    send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check(rts_out === 1'b0, "R10 rts low when full", int'(rts_out), 0);
    send_rx(8'h99, 1'b0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(rx_data === 8'h5A, "R10 held byte kept", int'(rx_data), 'h5A);
    rx_take = 1'b1;
    wait_rx_done();
    check(rts_out === 1'b1, "R10 rts high when empty", int'(rts_out), 1);
    check(rx_valid === 1'b0, "R10 dropped byte not delivered", int'(rx_valid), 0);

    check(txq.size() == 0 && rxq.size() == 0, "R6 scoreboards drained",
          txq.size() + rxq.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule